// File: doc/BRIEF.md
# DMA Channel Address and Count Register Bank

This block holds the programmed start address and transfer count of four DMA channels, together with the working state that follows a transfer in progress. Software reaches all of the registers through one byte-wide access port. Each register is 16 bits wide and takes two successive byte accesses. A single byte pointer, shared by every channel, decides whether an access touches the low byte or the high byte. Writing the high byte of either register of a channel restarts that channel. Its working address is loaded from the programmed address, and its progress counter returns to zero.

The transfer engine advances a channel with a one-cycle step pulse. The block then presents each channel's live address, its progress and its terminal length, so that the engine can tell when the transfer is complete. Readback is computed from the programmed values and the progress; it is not stored. A read of the address register returns the live address, which counts up or down as the per-channel direction input selects. A read of the count register returns the units still to go.

A shift parameter selects the word-wide variant. In that variant, port addresses and addresses are scaled by two, and progress is counted in bytes.

Top module: `dmab_addr_count_bank`

## Requirements
- R1: The register index is bits [3:0] of (acc_addr >> SHIFT). Index bits [3:1] give the channel number and index bit 0 selects the address register (0) or the count register (1). A channel number of NUM_CH or more hits no register: a write to it changes nothing, and a read of it returns 8'h00.
- R2: One byte pointer is shared by all channels and is 0 after reset. It inverts on every cycle with wr_en or rd_en high, including accesses to out-of-range channels. A cycle with ptr_clr high sets it to 0, and ptr_clr wins over an access in the same cycle.
- R3: A write with the pointer at 0 replaces bits [7:0] of the selected programmed register. A write with the pointer at 1 replaces bits [15:8]. The other byte is kept.
- R4: A high-byte write to either register of a channel sets the channel's working address to (programmed address << SHIFT), using the new value, and clears the channel's progress to 0. A low-byte write changes neither the working address nor the progress.
- R5: A cycle with xfer_step[i] high adds (1 << SHIFT) to the progress of channel i. If a high-byte write hits the same channel in the same cycle, the progress becomes 0.
- R6: cur_addr of a channel, and the value read from its address register, equal the working address plus the progress. When mode_dec[i] is high they equal the working address minus the progress instead. The result wraps modulo 2^(16+SHIFT).
- R7: The value read from a count register is (programmed count << SHIFT) minus progress, wrapping modulo 2^(17+SHIFT). It therefore reads 16'hFFFF when the progress is one unit past the programmed count.
- R8: A read returns bits [7:0] of the selected value shifted right by SHIFT when the pointer is 0, and bits [15:8] of that shifted value when the pointer is 1. The byte appears on rd_data in the cycle after rd_en and holds until the next read.
- R9: term_len of a channel equals (programmed count + 1) << SHIFT.
- R10: After a synchronous reset, all programmed values, working addresses, progress counters and rd_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_addr | input | ADDR_W | Port address of the register access |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Byte returned by the last read |
| ptr_clr | input | 1 | Clears the shared byte pointer |
| mode_dec | input | NUM_CH | Per-channel direction: 1 = address counts down |
| xfer_step | input | NUM_CH | Per-channel one-unit progress pulse from the transfer engine |
| cur_addr | output | NUM_CH*(16+SHIFT) | Live address of each channel, channel 0 in the low bits |
| progress | output | NUM_CH*(17+SHIFT) | Progress counter of each channel |
| term_len | output | NUM_CH*(17+SHIFT) | Terminal transfer length of each channel |

## Verification
The assertions assume that software never raises wr_en and rd_en in the same cycle, since the block defines no order for a combined access. One property checks this assumption. The stimulus drives one kind of operation per clock, with all other strobes low. The one exception is the pair of directed tests, which combine a high-byte write with a step, and an access with a pointer clear. All other properties assume only that the strobes are sampled high or low on the clock edge, and the bench always changes them on the falling edge.

// File: rtl/dmab_pkg.sv
// Shared definitions for the DMA address/count register bank.
// Assumes byte-wide register access to 16-bit registers.
package dmab_pkg;
    localparam int REG_W  = 16;
    localparam int BYTE_W = 8;

    // Which of the two registers of a channel an access selects.
    typedef enum logic {
        REG_ADDR = 1'b0,
        REG_CNT  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/dmab_byte_ptr.sv
// Shared low/high byte pointer for the register bank.
// Inverts on every access, and is forced to zero by a clear strobe.
// Assumes the caller never presents a read and a write in the same cycle.
module dmab_byte_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    input  logic clr,
    output logic ptr
);
    // Pointer state: clear wins, otherwise toggle on access.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr <= 1'b0;
        else if (clr)    ptr <= 1'b0;
        else if (access) ptr <= ~ptr;
    end

    // R2
    ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !clr) |=> (ptr != $past(ptr)));
    // R2
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ptr == 1'b0));
    // R2
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!access && !clr) |=> $stable(ptr));
endmodule

// File: rtl/dmab_chan_regs.sv
// Register set of one DMA channel: programmed address and count, working
// address, and progress counter. Also forms the live address, the remaining
// count and the terminal length. Assumes at most one of wr_lo and wr_hi is
// high in a cycle.
module dmab_chan_regs
    import dmab_pkg::*;
#(
    parameter int SHIFT  = 0,
    parameter int WORK_W = REG_W + SHIFT,
    parameter int PROG_W = REG_W + SHIFT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  reg_sel_e          reg_sel,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              step,
    input  logic              dec,
    output logic [WORK_W-1:0] live_addr,
    output logic [PROG_W-1:0] remain,
    output logic [PROG_W-1:0] prog,
    output logic [PROG_W-1:0] term_len
);
    localparam logic [PROG_W-1:0] UNIT = PROG_W'(1) << SHIFT;

    logic [REG_W-1:0]  base_addr;
    logic [REG_W-1:0]  base_cnt;
    logic [WORK_W-1:0] start_addr;
    logic [REG_W-1:0]  next_base_addr;

    // Programmed address as it stands after this cycle's write.
    always_comb begin
        next_base_addr = base_addr;
        if (wr_hi && reg_sel == REG_ADDR) next_base_addr[15:8] = wr_byte;
    end

    // Programmed registers: byte-wise update of the selected one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
        end else if (wr_lo) begin
            if (reg_sel == REG_CNT) base_cnt[7:0]  <= wr_byte;
            else                    base_addr[7:0] <= wr_byte;
        end else if (wr_hi) begin
            if (reg_sel == REG_CNT) base_cnt[15:8]  <= wr_byte;
            else                    base_addr[15:8] <= wr_byte;
        end
    end

    // Working state: reload on a high-byte write, else advance on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_addr <= '0;
            prog       <= '0;
        end else if (wr_hi) begin
            start_addr <= WORK_W'(next_base_addr) << SHIFT;
            prog       <= '0;
        end else if (step) begin
            prog <= prog + UNIT;
        end
    end

    // Derived views: live address, units left, terminal length.
    always_comb begin
        if (dec) live_addr = start_addr - prog[WORK_W-1:0];
        else     live_addr = start_addr + prog[WORK_W-1:0];
        remain   = (PROG_W'(base_cnt) << SHIFT) - prog;
        term_len = (PROG_W'(base_cnt) + PROG_W'(1)) << SHIFT;
    end

    // R4
    reload_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (start_addr == (WORK_W'(base_addr) << SHIFT)));
    // R4
    reload_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (prog == '0));
    // R4
    lo_no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !step) |=> ($stable(start_addr) && $stable(prog)));
    // R5
    step_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_hi) |=> (prog == $past(prog) + UNIT));
    // R3
    lo_keeps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> ($stable(base_addr[15:8]) && $stable(base_cnt[15:8])));
endmodule

// File: rtl/dmab_read_sel.sv
// Readback byte selection: picks the channel's live address or remaining
// count, scales it by the shift, and selects the byte named by the pointer.
// Returns zero for a channel number outside the bank.
module dmab_read_sel
    import dmab_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int SHIFT  = 0,
    parameter int CH_W   = 3,
    parameter int WORK_W = REG_W + SHIFT,
    parameter int PROG_W = REG_W + SHIFT + 1
) (
    input  logic [NUM_CH*WORK_W-1:0] live_flat,
    input  logic [NUM_CH*PROG_W-1:0] remain_flat,
    input  logic [CH_W-1:0]          ch,
    input  reg_sel_e                 reg_sel,
    input  logic                     in_range,
    input  logic                     ptr,
    output logic [BYTE_W-1:0]        rd_byte
);
    logic [PROG_W-1:0] val;

    // Channel/register selection followed by shift and byte pick.
    always_comb begin
        val = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (int'(ch) == i) begin
                if (reg_sel == REG_CNT) val = remain_flat[i*PROG_W +: PROG_W];
                else                    val = PROG_W'(live_flat[i*WORK_W +: WORK_W]);
            end
        end
        if (!in_range) rd_byte = '0;
        else           rd_byte = BYTE_W'(val >> (SHIFT + (ptr ? 8 : 0)));
    end
endmodule

// File: rtl/dmab_addr_count_bank.sv
// Address/count register bank for NUM_CH DMA channels behind one byte port.
// Decodes the port address, sequences bytes with a shared pointer, and
// exports the live address, progress and terminal length of each channel.
// Assumes wr_en and rd_en are never high together.
module dmab_addr_count_bank
    import dmab_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int SHIFT  = 0,
    parameter int ADDR_W = 5,
    localparam int WORK_W = REG_W + SHIFT,
    localparam int PROG_W = REG_W + SHIFT + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        acc_addr,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [7:0]               wr_data,
    output logic [7:0]               rd_data,
    input  logic                     ptr_clr,
    input  logic [NUM_CH-1:0]        mode_dec,
    input  logic [NUM_CH-1:0]        xfer_step,
    output logic [NUM_CH*WORK_W-1:0] cur_addr,
    output logic [NUM_CH*PROG_W-1:0] progress,
    output logic [NUM_CH*PROG_W-1:0] term_len
);
    localparam int CH_W = 3;

    logic [3:0]               reg_idx;
    logic [CH_W-1:0]          ch_num;
    reg_sel_e                 reg_sel;
    logic                     in_range;
    logic                     ptr;
    logic [NUM_CH*PROG_W-1:0] remain_flat;
    logic [BYTE_W-1:0]        rd_byte;

    // Port address decode into channel number and register select.
    always_comb begin
        reg_idx  = 4'(acc_addr >> SHIFT);
        ch_num   = reg_idx[3:1];
        reg_sel  = reg_sel_e'(reg_idx[0]);
        in_range = int'(ch_num) < NUM_CH;
    end

    dmab_byte_ptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .access (wr_en | rd_en),
        .clr    (ptr_clr),
        .ptr    (ptr)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        // Write hit for this channel.
        assign hit = wr_en && in_range && (int'(ch_num) == i);

        dmab_chan_regs #(
            .SHIFT  (SHIFT),
            .WORK_W (WORK_W),
            .PROG_W (PROG_W)
        ) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_lo     (hit && !ptr),
            .wr_hi     (hit && ptr),
            .reg_sel   (reg_sel),
            .wr_byte   (wr_data),
            .step      (xfer_step[i]),
            .dec       (mode_dec[i]),
            .live_addr (cur_addr[i*WORK_W +: WORK_W]),
            .remain    (remain_flat[i*PROG_W +: PROG_W]),
            .prog      (progress[i*PROG_W +: PROG_W]),
            .term_len  (term_len[i*PROG_W +: PROG_W])
        );
    end

    dmab_read_sel #(
        .NUM_CH (NUM_CH),
        .SHIFT  (SHIFT),
        .CH_W   (CH_W),
        .WORK_W (WORK_W),
        .PROG_W (PROG_W)
    ) u_rsel (
        .live_flat   (cur_addr),
        .remain_flat (remain_flat),
        .ch          (ch_num),
        .reg_sel     (reg_sel),
        .in_range    (in_range),
        .ptr         (ptr),
        .rd_byte     (rd_byte)
    );

    // Read data register: capture the selected byte on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_byte;
    end

    // R2 (input assumption: one access kind per cycle)
    no_dual_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));
    // R1
    oor_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !in_range) |=> (rd_data == 8'h00));
    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: tb/sim_dmab_addr_count_bank.sv
`timescale 1ns/1ps
module sim_dmab_addr_count_bank;
    localparam int OP_WR = 0, OP_RD = 1, OP_STEP = 2, OP_CLR = 3;
    localparam int NV = 53;
    // Vector = {op[1:0], addr[4:0], data[7:0], expected read byte[7:0]}
    localparam logic [22:0] VEC [NV] = '{
        {2'd0,5'd0,8'h34,8'h00}, // R2 R3 pointer starts at 0: low byte
        {2'd0,5'd0,8'h12,8'h00}, // R4 high write reloads ch0 = 0x1234
        {2'd0,5'd1,8'h05,8'h00},
        {2'd0,5'd1,8'h00,8'h00}, // ch0 count = 5
        {2'd1,5'd0,8'h00,8'h34}, // R8 low byte
        {2'd1,5'd0,8'h00,8'h12}, // R8 high byte
        {2'd2,5'd0,8'h01,8'h00},
        {2'd2,5'd0,8'h01,8'h00},
        {2'd2,5'd0,8'h01,8'h00}, // R5 three steps
        {2'd1,5'd0,8'h00,8'h37}, // R6 up count
        {2'd1,5'd0,8'h00,8'h12},
        {2'd1,5'd1,8'h00,8'h02}, // R7 5-3
        {2'd1,5'd1,8'h00,8'h00},
        {2'd0,5'd2,8'h00,8'h00},
        {2'd0,5'd2,8'h10,8'h00}, // ch1 = 0x1000
        {2'd2,5'd0,8'h02,8'h00},
        {2'd2,5'd0,8'h02,8'h00},
        {2'd1,5'd2,8'h00,8'hFE}, // R6 down count 0x0FFE
        {2'd1,5'd2,8'h00,8'h0F},
        {2'd0,5'd0,8'h78,8'h00}, // R4 low write, no reload
        {2'd1,5'd2,8'h00,8'h0F}, // R2 shared pointer: ch1 high byte
        {2'd1,5'd0,8'h00,8'h37}, // R4 ch0 still 0x1237
        {2'd1,5'd0,8'h00,8'h12},
        {2'd0,5'd4,8'hAA,8'h00},
        {2'd3,5'd0,8'h00,8'h00}, // R2 clear strobe
        {2'd0,5'd4,8'hBB,8'h00}, // R3 low replaced
        {2'd0,5'd4,8'h01,8'h00}, // ch2 = 0x01BB
        {2'd1,5'd4,8'h00,8'hBB},
        {2'd1,5'd4,8'h00,8'h01},
        {2'd0,5'd8,8'h55,8'h00}, // R1 out-of-range write still toggles
        {2'd1,5'd4,8'h00,8'h01}, // R1 R2 high byte read
        {2'd1,5'd8,8'h00,8'h00}, // R1 out-of-range read is zero
        {2'd1,5'd4,8'h00,8'h01},
        {2'd2,5'd0,8'h01,8'h00},
        {2'd2,5'd0,8'h01,8'h00},
        {2'd2,5'd0,8'h01,8'h00}, // ch0 progress 6
        {2'd1,5'd1,8'h00,8'hFF}, // R7 borrow past zero
        {2'd1,5'd1,8'h00,8'hFF},
        {2'd1,5'd0,8'h00,8'h3A},
        {2'd1,5'd0,8'h00,8'h12},
        {2'd0,5'd0,8'h9A,8'h00}, // R3 base 0x129A
        {2'd0,5'd0,8'h56,8'h00}, // R4 reload 0x569A
        {2'd1,5'd0,8'h00,8'h9A},
        {2'd1,5'd0,8'h00,8'h56},
        {2'd1,5'd1,8'h00,8'h05}, // R4 progress cleared
        {2'd1,5'd1,8'h00,8'h00},
        {2'd0,5'd6,8'hFF,8'h00},
        {2'd0,5'd6,8'hFF,8'h00},
        {2'd2,5'd0,8'h08,8'h00},
        {2'd1,5'd6,8'h00,8'h00}, // R6 wrap 0xFFFF+1
        {2'd1,5'd6,8'h00,8'h00},
        {2'd1,5'd7,8'h00,8'hFF}, // R7 0 minus 1
        {2'd1,5'd7,8'h00,8'hFF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [4:0]  a0, a1;
    logic        we0, re0, clr0, we1, re1, clr1;
    logic [7:0]  wd0, wd1, rd0, rd1;
    logic [3:0]  st0, st1;
    logic [3:0]  dec0 = 4'b0010;
    logic [63:0] cur0;
    logic [67:0] prog0, term0;
    logic [67:0] cur1;
    logic [71:0] prog1, term1;

    int n_chk = 0;
    int n_bad = 0;

    dmab_addr_count_bank u0 (
        .clk(clk), .rst_n(rst_n), .acc_addr(a0), .wr_en(we0), .rd_en(re0),
        .wr_data(wd0), .rd_data(rd0), .ptr_clr(clr0), .mode_dec(dec0),
        .xfer_step(st0), .cur_addr(cur0), .progress(prog0), .term_len(term0)
    );

    dmab_addr_count_bank #(.SHIFT(1)) u1 (
        .clk(clk), .rst_n(rst_n), .acc_addr(a1), .wr_en(we1), .rd_en(re1),
        .wr_data(wd1), .rd_data(rd1), .ptr_clr(clr1), .mode_dec(4'b0000),
        .xfer_step(st1), .cur_addr(cur1), .progress(prog1), .term_len(term1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        we0 = 0; re0 = 0; clr0 = 0; st0 = 0; we1 = 0; re1 = 0; clr1 = 0; st1 = 0;
    endtask

    // One operation on the selected instance, held for one rising edge.
    task automatic op(input bit inst, input int kind, input logic [4:0] ad, input logic [7:0] d);
        @(negedge clk);
        if (!inst) begin
            a0 = ad; wd0 = d;
            we0 = (kind == OP_WR); re0 = (kind == OP_RD);
            clr0 = (kind == OP_CLR); st0 = (kind == OP_STEP) ? d[3:0] : 4'd0;
        end else begin
            a1 = ad; wd1 = d;
            we1 = (kind == OP_WR); re1 = (kind == OP_RD);
            clr1 = (kind == OP_CLR); st1 = (kind == OP_STEP) ? d[3:0] : 4'd0;
        end
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(); a0 = 0; a1 = 0; wd0 = 0; wd1 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 rd_data", 32'(rd0), 32'h0);
        chk("R10 progress", 32'(prog0[16:0]), 32'h0);
        chk("R10 cur_addr", 32'(cur0[15:0]), 32'h0);
        chk("R9 term_len after reset", 32'(term0[16:0]), 32'h1);

        for (int i = 0; i < NV; i++) begin
            op(1'b0, int'(VEC[i][22:21]), VEC[i][20:16], VEC[i][15:8]);
            if (int'(VEC[i][22:21]) == OP_RD)
                chk($sformatf("R8 vector %0d", i), 32'(rd0), 32'(VEC[i][7:0]));
        end

        // R6 R9 R5 port views after the table
        chk("R6 ch0 cur_addr", 32'(cur0[15:0]), 32'h569A);
        chk("R4 ch0 progress", 32'(prog0[16:0]), 32'h0);
        chk("R9 ch0 term_len", 32'(term0[16:0]), 32'h6);
        chk("R6 ch1 cur_addr", 32'(cur0[31:16]), 32'h0FFE);
        chk("R6 ch3 cur_addr", 32'(cur0[63:48]), 32'h0000);
        chk("R5 ch3 progress", 32'(prog0[67:51]), 32'h1);
        chk("R9 ch3 term_len", 32'(term0[67:51]), 32'h1);

        // R5 reload beats step in the same cycle
        op(1'b0, OP_STEP, 5'd0, 8'h04);
        chk("R5 ch2 step", 32'(prog0[50:34]), 32'h1);
        op(1'b0, OP_WR, 5'd4, 8'h10);
        @(negedge clk);
        a0 = 5'd4; wd0 = 8'h02; we0 = 1; st0 = 4'b0100;
        @(negedge clk);
        idle();
        chk("R5 reload wins", 32'(prog0[50:34]), 32'h0);
        chk("R4 ch2 cur_addr", 32'(cur0[47:32]), 32'h0210);

        // R2 clear wins over a write in the same cycle
        @(negedge clk);
        a0 = 5'd0; wd0 = 8'h11; we0 = 1; clr0 = 1;
        @(negedge clk);
        idle();
        op(1'b0, OP_RD, 5'd0, 8'h00);
        chk("R2 clear beats access", 32'(rd0), 32'h9A);
        op(1'b0, OP_RD, 5'd0, 8'h00);
        chk("R2 next byte high", 32'(rd0), 32'h56);

        // R1 R6 R7 R9 word-wide variant, SHIFT = 1
        op(1'b1, OP_WR, 5'd0, 8'h34);
        op(1'b1, OP_WR, 5'd0, 8'h12);
        op(1'b1, OP_WR, 5'd2, 8'h03);
        op(1'b1, OP_WR, 5'd2, 8'h00);
        op(1'b1, OP_STEP, 5'd0, 8'h01);
        chk("R5 shift step", 32'(prog1[17:0]), 32'h2);
        chk("R6 shift cur_addr", 32'(cur1[16:0]), 32'h246A);
        chk("R9 shift term_len", 32'(term1[17:0]), 32'h8);
        op(1'b1, OP_RD, 5'd0, 8'h00);
        chk("R8 shift addr low", 32'(rd1), 32'h35);
        op(1'b1, OP_RD, 5'd0, 8'h00);
        chk("R8 shift addr high", 32'(rd1), 32'h12);
        op(1'b1, OP_RD, 5'd2, 8'h00);
        chk("R7 shift count low", 32'(rd1), 32'h02);
        op(1'b1, OP_RD, 5'd2, 8'h00);
        chk("R7 shift count high", 32'(rd1), 32'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule